// File: doc/BRIEF.md
# Multiplexed Byte-Lane Host Register Bridge

This block sits on the device side of a narrow host port, where a host toggles general-purpose pins to reach a bank of up to sixteen byte-wide registers. One 8-bit bidirectional lane carries both the register index and the data. A separate select pin tells the bridge which of the two the current strobe carries. An access therefore comes in two parts. A write with select high loads the register index into a latch. Each later strobe with select low moves one byte to or from the register that the latch points at.

The control pins arrive asynchronously, so they pass through a synchroniser of configurable depth. Edges on the synchronised strobes become single-cycle internal strobes for the attached register owners. Each strobe comes with the latched index, and write strobes also carry the data byte. The bridge answers every strobe on an active-low ready line and holds ready low until the host releases the strobe. The highest index is served inside the bridge as a fixed revision byte. The bridge also merges interrupt requests from the attached blocks into one active-low interrupt pin for the host.

Top module: `hostbyte_bridge`

## Requirements
- R1: After reset, ready (`hb_rdy_n`) and interrupt (`hb_irq_n`) are high, both internal strobes are low, and the data lane is not driven.
- R2: A write strobe (`hb_wr_n` low) with chip select low and `hb_sel` high (1 = index phase, 0 = data phase) loads the low `IDX_W` bits of the lane into `reg_idx` and produces no internal write strobe.
- R3: The latched index stays the same through any number of data-phase accesses, until the next index-phase write.
- R4: A data-phase write to any index except all-ones produces one `reg_wr_stb` pulse lasting exactly one clock. During that pulse `reg_idx` holds the latched index and `reg_wdata` holds the lane byte.
- R5: A data-phase read to any index except all-ones produces one `reg_rd_stb` pulse lasting one clock. The bridge then presents `reg_rdata` on the lane, so a register reads back the value last written to it.
- R6: Index all-ones (0x0F) reads back `REVISION` (default 0x5A) and raises no internal read strobe. A write to it raises no internal write strobe.
- R7: The lane is driven only while `hb_cs_n` and `hb_rd_n` are both low. While chip select is high, strobes have no effect: no ready, and no internal strobe.
- R8: Ready goes low exactly `SYNC_STAGES`+2 clocks after a strobe falls. It goes high again within `SYNC_STAGES`+1 clocks after the strobe rises.
- R9: A read with `hb_sel` high returns the latched index, zero-extended to the lane width.
- R10: `hb_irq_n` goes low one clock after any `irq_src` bit is high. It returns high one clock after all bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_sel | input | 1 | 1 = index phase, 0 = data phase |
| hb_wr_n | input | 1 | Host write strobe, active low |
| hb_rd_n | input | 1 | Host read strobe, active low |
| hb_data | inout | DATA_W | Shared index/data lane |
| hb_rdy_n | output | 1 | Ready handshake to host, active low |
| hb_irq_n | output | 1 | Interrupt to host, active low |
| irq_src | input | IRQ_W | Interrupt requests from attached blocks |
| reg_wr_stb | output | 1 | Single-cycle internal write strobe |
| reg_rd_stb | output | 1 | Single-cycle internal read strobe |
| reg_idx | output | IDX_W | Latched register index |
| reg_wdata | output | DATA_W | Write data for the attached register |
| reg_rdata | input | DATA_W | Read data from the attached register selected by reg_idx |

## Verification
The bench builds the bridge with its defaults: an 8-bit lane, a 4-bit index, a two-stage synchroniser, index-phase readback enabled and a 0x5A revision byte. With two stages, the ready latency is a short, fixed count that the bench can check to the exact clock. The sixteen-entry index space is small enough that the bench can attach a full register model behind the strobes and check read-modify-write round trips on several indices. It also reaches the all-ones revision slot directly.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
   // Source of the byte returned by a completed read
   typedef enum logic [1:0] {
      RK_NONE     = 2'd0,
      RK_INDEX    = 2'd1,
      RK_REVISION = 2'd2,
      RK_REGISTER = 2'd3
   } rd_kind_e;
endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
   parameter int             W       = 4,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbb_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hbb_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= din;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/hbb_phase.sv
module hbb_phase
   import hbb_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int IDX_W      = 4,
   parameter bit ADDR_RD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sel_s,
   input  logic              wr_n_s,
   input  logic              rd_n_s,
   input  logic [DATA_W-1:0] din,
   output logic              act_any,
   output logic              acc_done,
   output logic              acc_is_rd,
   output rd_kind_e          rd_kind,
   output logic              reg_wr_stb,
   output logic              reg_rd_stb,
   output logic [IDX_W-1:0]  reg_idx,
   output logic [DATA_W-1:0] reg_wdata
);
   if (DATA_W < IDX_W) begin : g_bad_widths
      $error("hbb_phase: DATA_W must not be smaller than IDX_W");
   end

   localparam logic [IDX_W-1:0] REV_IDX = '1;

   rd_kind_e index_kind;
   if (ADDR_RD_EN) begin : g_idx_rd
      assign index_kind = RK_INDEX;
   end else begin : g_no_idx_rd
      assign index_kind = RK_NONE;
   end

   logic wr_act, rd_act, wr_act_q, rd_act_q;
   logic wr_pulse, rd_pulse;

   assign wr_act   = !cs_n_s && !wr_n_s;
   assign rd_act   = !cs_n_s && !rd_n_s;
   assign act_any  = wr_act || rd_act;
   assign wr_pulse = wr_act && !wr_act_q;
   assign rd_pulse = rd_act && !rd_act_q && !wr_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q   <= 1'b0;
         rd_act_q   <= 1'b0;
         acc_done   <= 1'b0;
         acc_is_rd  <= 1'b0;
         rd_kind    <= RK_NONE;
         reg_wr_stb <= 1'b0;
         reg_rd_stb <= 1'b0;
         reg_idx    <= '0;
         reg_wdata  <= '0;
      end else begin
         wr_act_q   <= wr_act;
         rd_act_q   <= rd_act;
         acc_done   <= wr_pulse || rd_pulse;
         acc_is_rd  <= rd_pulse;
         reg_wr_stb <= 1'b0;
         reg_rd_stb <= 1'b0;
         if (wr_pulse) begin
            if (sel_s) begin
               reg_idx <= din[IDX_W-1:0];
            end else if (reg_idx != REV_IDX) begin
               reg_wr_stb <= 1'b1;
               reg_wdata  <= din;
            end
         end else if (rd_pulse) begin
            if (sel_s) begin
               rd_kind <= index_kind;
            end else if (reg_idx == REV_IDX) begin
               rd_kind <= RK_REVISION;
            end else begin
               rd_kind    <= RK_REGISTER;
               reg_rd_stb <= 1'b1;
            end
         end
      end
   end

   // R4: internal write strobe lasts one clock
   a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_stb |=> !reg_wr_stb);
   // R5: internal read strobe lasts one clock
   a_r5_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_stb |=> !reg_rd_stb);
   // R3: index moves only on an index-phase write
   a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_pulse && sel_s) |=> $stable(reg_idx));
   // R7: an internal strobe follows a selected strobe seen one clock before
   a_r7_stb_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_stb || reg_rd_stb) |-> $past(act_any));
   // R5: never both strobes at once
   a_r5_stb_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_stb && reg_rd_stb));
endmodule

// File: rtl/hbb_readback.sv
module hbb_readback
   import hbb_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                IDX_W    = 4,
   parameter logic [DATA_W-1:0] REVISION = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_any,
   input  logic              acc_done,
   input  logic              acc_is_rd,
   input  rd_kind_e          rd_kind,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] rd_buf,
   output logic              rdy_n
);
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      unique case (rd_kind)
         RK_INDEX:    rd_next = DATA_W'(reg_idx);
         RK_REVISION: rd_next = REVISION;
         RK_REGISTER: rd_next = reg_rdata;
         default:     rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_n  <= 1'b1;
         rd_buf <= '0;
      end else begin
         if (!act_any)      rdy_n <= 1'b1;
         else if (acc_done) rdy_n <= 1'b0;
         if (acc_done && acc_is_rd) rd_buf <= rd_next;
      end
   end

   // R8: ready released once the strobe is gone
   a_r8_rdy_release: assert property (@(posedge clk) disable iff (!rst_n)
      !act_any |=> rdy_n);
   // R8: ready only falls after a detected access
   a_r8_rdy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_n) |-> $past(acc_done));
endmodule

// File: rtl/hostbyte_bridge.sv
module hostbyte_bridge
   import hbb_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                IDX_W       = 4,
   parameter int                SYNC_STAGES = 2,
   parameter int                IRQ_W       = 2,
   parameter bit                ADDR_RD_EN  = 1'b1,
   parameter logic [DATA_W-1:0] REVISION    = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hb_cs_n,
   input  logic              hb_sel,
   input  logic              hb_wr_n,
   input  logic              hb_rd_n,
   inout  wire  [DATA_W-1:0] hb_data,
   output logic              hb_rdy_n,
   output logic              hb_irq_n,
   input  logic [IRQ_W-1:0]  irq_src,
   output logic              reg_wr_stb,
   output logic              reg_rd_stb,
   output logic [IDX_W-1:0]  reg_idx,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata
);
   if (IRQ_W < 1) begin : g_bad_irq
      $error("hostbyte_bridge: IRQ_W must be at least 1");
   end

   // Synchronised control pins: {cs_n, sel, wr_n, rd_n}
   localparam int CTL_W = 4;
   localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1011;

   logic [CTL_W-1:0] ctl_s;
   logic             act_any, acc_done, acc_is_rd;
   rd_kind_e         rd_kind;
   logic [DATA_W-1:0] rd_buf;

   hbb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({hb_cs_n, hb_sel, hb_wr_n, hb_rd_n}),
      .dout (ctl_s)
   );

   hbb_phase #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_RD_EN(ADDR_RD_EN)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (ctl_s[3]),
      .sel_s     (ctl_s[2]),
      .wr_n_s    (ctl_s[1]),
      .rd_n_s    (ctl_s[0]),
      .din       (hb_data),
      .act_any   (act_any),
      .acc_done  (acc_done),
      .acc_is_rd (acc_is_rd),
      .rd_kind   (rd_kind),
      .reg_wr_stb(reg_wr_stb),
      .reg_rd_stb(reg_rd_stb),
      .reg_idx   (reg_idx),
      .reg_wdata (reg_wdata)
   );

   hbb_readback #(.DATA_W(DATA_W), .IDX_W(IDX_W), .REVISION(REVISION)) u_rdbk (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_any  (act_any),
      .acc_done (acc_done),
      .acc_is_rd(acc_is_rd),
      .rd_kind  (rd_kind),
      .reg_idx  (reg_idx),
      .reg_rdata(reg_rdata),
      .rd_buf   (rd_buf),
      .rdy_n    (hb_rdy_n)
   );

   assign hb_data = (!hb_cs_n && !hb_rd_n) ? rd_buf : {DATA_W{1'bz}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hb_irq_n <= 1'b1;
      else        hb_irq_n <= ~(|irq_src);
   end

   // R10: interrupt pin follows the request set one clock later
   a_r10_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_src) |=> !hb_irq_n);
   a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !(|irq_src) |=> hb_irq_n);
endmodule

// File: tb/hostbyte_bridge_tb.sv
module hostbyte_bridge_tb_top;
   localparam int  NSYNC = 2;
   localparam logic [7:0] REV = 8'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hb_cs_n = 1'b1, hb_sel = 1'b0, hb_wr_n = 1'b1, hb_rd_n = 1'b1;
   logic tb_oe = 1'b0;
   logic [7:0] tb_d = 8'h00;
   wire  [7:0] hb_data;
   logic hb_rdy_n, hb_irq_n;
   logic [1:0] irq_src = 2'b00;
   logic reg_wr_stb, reg_rd_stb;
   logic [3:0] reg_idx;
   logic [7:0] reg_wdata, reg_rdata;

   logic [7:0] regs [16];
   int checks = 0, failures = 0;
   int wr_cnt = 0, rd_cnt = 0;
   logic [3:0] last_widx;
   logic [7:0] last_wdata;

   always #10 clk = ~clk;

   assign hb_data = tb_oe ? tb_d : 8'bzzzzzzzz;
   for (genvar gi = 0; gi < 8; gi++) begin : g_pu
      pullup (hb_data[gi]);
   end
   assign reg_rdata = regs[reg_idx];

   hostbyte_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .hb_cs_n(hb_cs_n), .hb_sel(hb_sel),
      .hb_wr_n(hb_wr_n), .hb_rd_n(hb_rd_n), .hb_data(hb_data),
      .hb_rdy_n(hb_rdy_n), .hb_irq_n(hb_irq_n), .irq_src(irq_src),
      .reg_wr_stb(reg_wr_stb), .reg_rd_stb(reg_rd_stb), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   // Attached register model, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n && reg_wr_stb) begin
         wr_cnt++;
         last_widx  = reg_idx;
         last_wdata = reg_wdata;
         regs[reg_idx] = reg_wdata;
      end
      if (rst_n && reg_rd_stb) rd_cnt++;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // One host strobe; returns lane byte at ready, ready latency and release time
   task automatic bus_op(input logic sel, input logic is_rd, input logic [7:0] wd,
                         output logic [7:0] rd, output int lat, output int rel);
      @(negedge clk);
      hb_cs_n = 1'b0; hb_sel = sel; tb_d = wd; tb_oe = !is_rd;
      @(negedge clk);
      if (is_rd) hb_rd_n = 1'b0; else hb_wr_n = 1'b0;
      lat = 0;
      do begin @(negedge clk); lat++; end while (hb_rdy_n && lat < 40);
      rd = hb_data;
      hb_rd_n = 1'b1; hb_wr_n = 1'b1;
      rel = 0;
      do begin @(negedge clk); rel++; end while (!hb_rdy_n && rel < 40);
      hb_cs_n = 1'b1; tb_oe = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic set_index(input logic [7:0] v);
      logic [7:0] d; int l, r;
      bus_op(1'b1, 1'b0, v, d, l, r);
   endtask
   task automatic wr_reg(input logic [7:0] v);
      logic [7:0] d; int l, r;
      bus_op(1'b0, 1'b0, v, d, l, r);
   endtask
   task automatic rd_reg(output logic [7:0] v);
      int l, r;
      bus_op(1'b0, 1'b1, 8'h00, v, l, r);
   endtask

   task automatic t_reset();
      check("R1 rdy_n", hb_rdy_n, 1);
      check("R1 irq_n", hb_irq_n, 1);
      check("R1 wr_stb", reg_wr_stb, 0);
      check("R1 rd_stb", reg_rd_stb, 0);
      check("R1 lane undriven", hb_data, 8'hFF);
   endtask

   task automatic t_index_latch();
      int w0 = wr_cnt;
      set_index(8'hA3);
      check("R2 index latched", reg_idx, 4'h3);
      check("R2 no write strobe", wr_cnt, w0);
   endtask

   task automatic t_write_read();
      logic [7:0] v; int w0, r0;
      set_index(8'h03);
      w0 = wr_cnt;
      wr_reg(8'h3C);
      check("R4 one strobe", wr_cnt, w0 + 1);
      check("R4 strobe index", last_widx, 4'h3);
      check("R4 strobe data", last_wdata, 8'h3C);
      r0 = rd_cnt;
      rd_reg(v);
      check("R5 readback", v, 8'h3C);
      check("R5 one read strobe", rd_cnt, r0 + 1);
      // read-modify-write on a second register
      set_index(8'h0C);
      wr_reg(8'h81);
      rd_reg(v);
      wr_reg(v | 8'h10);
      rd_reg(v);
      check("R5 rmw readback", v, 8'h91);
   endtask

   task automatic t_hold();
      logic [7:0] v;
      set_index(8'h05);
      wr_reg(8'h11);
      wr_reg(8'h22);
      wr_reg(8'h47);
      check("R3 index held", reg_idx, 4'h5);
      check("R3 last write target", last_widx, 4'h5);
      rd_reg(v);
      check("R3 value after writes", v, 8'h47);
      set_index(8'h07);
      wr_reg(8'h99);
      set_index(8'h05);
      rd_reg(v);
      check("R3 neighbour untouched", v, 8'h47);
   endtask

   task automatic t_revision();
      logic [7:0] v; int w0, r0;
      set_index(8'h0F);
      r0 = rd_cnt;
      rd_reg(v);
      check("R6 revision", v, REV);
      check("R6 no read strobe", rd_cnt, r0);
      w0 = wr_cnt;
      wr_reg(8'h11);
      check("R6 write ignored", wr_cnt, w0);
      rd_reg(v);
      check("R6 revision after write", v, REV);
   endtask

   task automatic t_index_read();
      logic [7:0] v; int l, r;
      set_index(8'h09);
      bus_op(1'b1, 1'b1, 8'h00, v, l, r);
      check("R9 index read", v, 8'h09);
   endtask

   task automatic t_timing();
      logic [7:0] v; int l, r;
      set_index(8'h02);
      bus_op(1'b0, 1'b0, 8'h6E, v, l, r);
      check("R8 write ready latency", l, NSYNC + 2);
      check("R8 write release", r <= NSYNC + 1, 1);
      bus_op(1'b0, 1'b1, 8'h00, v, l, r);
      check("R8 read ready latency", l, NSYNC + 2);
      check("R8 read release", r <= NSYNC + 1, 1);
      check("R5 read data", v, 8'h6E);
   endtask

   task automatic t_cs_gate();
      int w0 = wr_cnt, r0 = rd_cnt, low = 0;
      @(negedge clk);
      hb_cs_n = 1'b1; hb_sel = 1'b0; tb_oe = 1'b1; tb_d = 8'h55;
      hb_wr_n = 1'b0;
      repeat (10) begin @(negedge clk); if (!hb_rdy_n) low++; end
      hb_wr_n = 1'b1; tb_oe = 1'b0;
      hb_rd_n = 1'b0;
      repeat (10) begin @(negedge clk); if (!hb_rdy_n) low++; end
      check("R7 lane idle without cs", hb_data, 8'hFF);
      hb_rd_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R7 no ready without cs", low, 0);
      check("R7 no write strobe", wr_cnt, w0);
      check("R7 no read strobe", rd_cnt, r0);
      check("R7 index unchanged", reg_idx, 4'h2);
   endtask

   task automatic t_irq();
      @(negedge clk); irq_src = 2'b10;
      @(negedge clk);
      check("R10 irq asserted", hb_irq_n, 0);
      irq_src = 2'b01;
      @(negedge clk);
      check("R10 irq other source", hb_irq_n, 0);
      irq_src = 2'b00;
      @(negedge clk);
      check("R10 irq cleared", hb_irq_n, 1);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) regs[i] = 8'h00;
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_index_latch();
      t_write_read();
      t_hold();
      t_revision();
      t_index_read();
      t_timing();
      t_cs_gate();
      t_irq();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule